// File: doc/BRIEF.md
# Phase-Skew Ramping PWM Generator

This block drives one pulse-width modulated output. Its duty cycle is not compared against a stored duty value. It is the phase skew between two counters that count modulo `TERM+1` on the same clock. The output goes high when the leading ("rise") counter rolls over its terminal value, and it goes low when the trailing ("fall") counter rolls over. The high time per period is therefore equal to the skew in cycles.

Duty is changed one step at a time. An internal prescaler emits a one-cycle ramp tick every `tick_per+1` clock cycles. On each tick, one of the counters gets a second increment in that cycle: the rise counter when `ramp_dir` is high, the fall counter when it is low. A `hold` input keeps the prescaler in reset and so freezes the duty. A `zero_req` input snaps the duty to 0%. At the top of the range the skew stops at `TERM`, and the output is then held high for a clean 100%. At the bottom the skew stops at zero, and the output is held low with no stray pulses.

Top module: `phase_pwm`

## Requirements
- R1: After reset the skew is zero and `pwm_out` is low in every cycle.
- R2: With a steady skew d, where 0 < d < TERM, `pwm_out` is high for exactly d cycles out of every TERM+1 consecutive cycles.
- R3: A ramp tick with `ramp_dir`=1 raises the skew by one. Once the skew is TERM, further up ticks are ignored and `pwm_out` stays high in every cycle (100%).
- R4: A ramp tick with `ramp_dir`=0 lowers the skew by one. At skew zero, further down ticks are ignored and `pwm_out` stays low in every cycle, with no glitch pulses.
- R5: While `hold` is low, the prescaler starts from zero and gives exactly one ramp tick per `tick_per+1` cycles. A ramp from 0% to 100% therefore takes TERM ticks, and TERM-1 ticks leave the duty below 100%.
- R6: While `hold` is high, no ramp tick occurs and the duty does not change.
- R7: A cycle with `zero_req` high sets the skew to zero, and `pwm_out` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ramp_dir | input | 1 | Ramp direction: 1 raises the duty, 0 lowers it |
| hold | input | 1 | Freezes the duty by holding the tick prescaler in reset |
| zero_req | input | 1 | Forces the duty to 0% |
| tick_per | input | TICK_W (16) | Ramp tick spacing minus one, in clock cycles |
| pwm_out | output | 1 | PWM output |

## Verification
A corrupt skew between the counters shows at the port within one output period: the count of high cycles in any window of TERM+1 cycles differs from the number of net steps commanded. A lost or duplicated extra increment moves that count by one and keeps it wrong for as long as the duty is frozen. A missed saturation block shows in the first period after an over-ramp, as a wrap to a low duty or a stray pulse. A prescaler that miscounts shows as a step total that differs from the number of ticks that fit in the hold-low window.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
   // index of each counter in the counter pair
   typedef enum int unsigned {
      SIDE_RISE = 0,
      SIDE_FALL = 1
   } side_e;

   localparam int unsigned NUM_SIDES = 2;

   function automatic int unsigned skew_width(input int unsigned term);
      return $clog2(term + 1);
   endfunction
endpackage

// File: rtl/ramp_tick.sv
module ramp_tick #(
   parameter int unsigned TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [TICK_W-1:0] per,
   output logic              tick
);
   logic [TICK_W-1:0] cnt;

   assign tick = !hold && (cnt == per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (hold || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/phase_ctr.sv
module phase_ctr #(
   parameter int unsigned TERM = 15,
   parameter int unsigned CW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          bump,
   output logic [CW-1:0] cnt,
   output logic          wrap
);
   localparam logic [CW:0] MODV = (CW+1)'(TERM + 1);

   logic [CW:0] sum;
   logic [CW:0] nxt;

   always_comb begin
      sum  = {1'b0, cnt} + {{CW{1'b0}}, 1'b1} + {{CW{1'b0}}, bump};
      nxt  = (sum >= MODV) ? (sum - MODV) : sum;
      wrap = !clr && (sum >= MODV);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else begin
         cnt <= nxt[CW-1:0];
      end
   end
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
   import phase_pwm_pkg::*;
#(
   parameter int unsigned TERM   = 15,
   parameter int unsigned TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ramp_dir,
   input  logic              hold,
   input  logic              zero_req,
   input  logic [TICK_W-1:0] tick_per,
   output logic              pwm_out
);
   localparam int unsigned CW   = skew_width(TERM);
   localparam logic [CW:0] MODV = (CW+1)'(TERM + 1);
   localparam logic [CW-1:0] TOP = CW'(TERM);

   initial begin
      assert (TERM >= 3) else $error("phase_pwm: TERM must be at least 3");
      assert (TICK_W >= 1 && TICK_W <= 32) else $error("phase_pwm: TICK_W out of range");
   end

   logic                 tick;
   logic [CW-1:0]        cnt  [NUM_SIDES];
   logic [NUM_SIDES-1:0] wrap;
   logic [NUM_SIDES-1:0] bump;
   logic [CW:0]          diff;
   logic [CW-1:0]        offset;
   logic                 sat_hi;
   logic                 sat_lo;
   logic                 pwm_q;

   ramp_tick #(.TICK_W(TICK_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .per   (tick_per),
      .tick  (tick)
   );

   // skew = (rise - fall) mod (TERM+1)
   always_comb begin
      diff = {1'b0, cnt[SIDE_RISE]} - {1'b0, cnt[SIDE_FALL]};
      if (cnt[SIDE_RISE] < cnt[SIDE_FALL]) begin
         diff = diff + MODV;
      end
      offset = diff[CW-1:0];
      sat_hi = (offset == TOP);
      sat_lo = (offset == '0);
      bump[SIDE_RISE] = tick &&  ramp_dir && !sat_hi && !zero_req;
      bump[SIDE_FALL] = tick && !ramp_dir && !sat_lo && !zero_req;
   end

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      phase_ctr #(.TERM(TERM), .CW(CW)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (zero_req),
         .bump  (bump[s]),
         .cnt   (cnt[s]),
         .wrap  (wrap[s])
      );
   end

   // fall rollover wins when both coincide, so zero skew stays low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else if (zero_req || wrap[SIDE_FALL]) begin
         pwm_q <= 1'b0;
      end else if (wrap[SIDE_RISE]) begin
         pwm_q <= 1'b1;
      end
   end

   assign pwm_out = sat_lo ? 1'b0 : (sat_hi ? 1'b1 : pwm_q);
endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk #(
   parameter int unsigned TERM = 15,
   parameter int unsigned CW   = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ramp_dir,
   input logic          hold,
   input logic          zero_req,
   input logic          tick,
   input logic [CW-1:0] offset,
   input logic          pwm_out
);
   localparam logic [CW-1:0] ONE = CW'(1);
   localparam logic [CW-1:0] TOP = CW'(TERM);

   assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !tick);

   assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !zero_req) |=> $stable(offset));

   assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ramp_dir && !zero_req && offset != TOP) |=> offset == $past(offset) + ONE);

   assert_up_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ramp_dir && !zero_req && offset == TOP) |=> (offset == TOP && pwm_out));

   assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ramp_dir && !zero_req && offset != '0) |=> offset == $past(offset) - ONE);

   assert_down_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ramp_dir && !zero_req && offset == '0) |=> (offset == '0 && !pwm_out));

   assert_zero_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      zero_req |=> (offset == '0 && !pwm_out));
endmodule

bind phase_pwm phase_pwm_chk #(.TERM(TERM), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ramp_dir (ramp_dir),
   .hold     (hold),
   .zero_req (zero_req),
   .tick     (tick),
   .offset   (offset),
   .pwm_out  (pwm_out)
);

// File: tb/phase_pwm_test.sv
`timescale 1ns/1ps
module phase_pwm_test;
   localparam int N  = 15;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ramp_dir = 1'b0;
   logic          hold = 1'b1;
   logic          zero_req = 1'b0;
   logic [TW-1:0] tick_per = '0;
   logic          pwm_out;

   int total = 0;
   int bad = 0;
   int exp_d = 0;
   bit done = 0;

   always #2 clk = ~clk;

   phase_pwm #(.TERM(N), .TICK_W(TW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ramp_dir (ramp_dir),
      .hold     (hold),
      .zero_req (zero_req),
      .tick_per (tick_per),
      .pwm_out  (pwm_out)
   );

   function automatic int exp_high(input int d);
      return (d >= N) ? N + 1 : d;
   endfunction

   function automatic int step_model(input int d, input bit up, input int k);
      int r = up ? d + k : d - k;
      if (r > N) r = N;
      if (r < 0) r = 0;
      return r;
   endfunction

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic measure(input int periods, output int hi);
      repeat (2 * (N + 1)) @(posedge clk);
      hi = 0;
      repeat (periods * (N + 1)) begin
         @(negedge clk);
         hi += int'(pwm_out);
      end
   endtask

   // release hold for k*(per+1) edges: exactly k ticks
   task automatic ramp(input bit up, input int k, input int per);
      @(negedge clk);
      tick_per = TW'(per);
      ramp_dir = up;
      @(negedge clk);
      hold = 1'b0;
      repeat (k * (per + 1)) @(posedge clk);
      @(negedge clk);
      hold = 1'b1;
      exp_d = step_model(exp_d, up, k);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      finish_run();
   end

   initial begin
      int hi;
      void'($urandom(32'd1234));
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      measure(3, hi);
      check("R1 reset low", hi, 0);

      // R2 partial duty
      ramp(1'b1, 3, 2);
      measure(2, hi);
      check("R2 duty 3 steps", hi, 2 * exp_high(exp_d));

      // R6 hold freezes duty even with direction up for a long time
      @(negedge clk);
      ramp_dir = 1'b1;
      repeat (60) @(posedge clk);
      measure(1, hi);
      check("R6 hold keeps duty", hi, exp_high(exp_d));

      // R4 down past zero is blocked, output clean low
      ramp(1'b0, 5, 0);
      measure(4, hi);
      check("R4 floor clean low", hi, 0);
      check("R4 model at zero", exp_d, 0);

      // R5 TERM-1 ticks stay below full, TERM-th reaches 100%
      ramp(1'b1, N - 1, 1);
      measure(1, hi);
      check("R5 TERM-1 ticks", hi, N - 1);
      ramp(1'b1, 1, 3);
      measure(2, hi);
      check("R5 TERM ticks full", hi, 2 * (N + 1));

      // R3 extra up ticks blocked at 100%
      ramp(1'b1, 4, 0);
      measure(3, hi);
      check("R3 ceiling held", hi, 3 * (N + 1));

      // R3/R4 one step down from full
      ramp(1'b0, 1, 2);
      measure(1, hi);
      check("R4 step from full", hi, N - 1);

      // R4 full ramp down
      ramp(1'b0, N, 0);
      measure(2, hi);
      check("R4 full ramp down", hi, 0);

      // R7 zero request from mid duty
      ramp(1'b1, 7, 1);
      measure(1, hi);
      check("R2 duty 7 steps", hi, 7);
      @(negedge clk);
      zero_req = 1'b1;
      @(negedge clk);
      zero_req = 1'b0;
      exp_d = 0;
      check("R7 low next cycle", int'(pwm_out), 0);
      measure(3, hi);
      check("R7 zero duty", hi, 0);

      // random mix
      for (int i = 0; i < 24; i++) begin
         bit up = 1'($urandom_range(0, 1));
         int k = int'($urandom_range(1, 6));
         int per = int'($urandom_range(0, 3));
         ramp(up, k, per);
         measure(1, hi);
         if (exp_d == N)      check("R3 random full", hi, N + 1);
         else if (exp_d == 0) check("R4 random zero", hi, 0);
         else                 check("R2 random duty", hi, exp_d);
      end

      finish_run();
   end
endmodule